// File: doc/BRIEF.md
# Serial Management Interface Master with Register Control

This block runs clause-22 management transactions towards an Ethernet PHY. Software programs a command word (PHY address, register number and direction) and, for writes, a 16-bit data value. It then sets a start bit in a control register. The block shifts out one complete 64-bit management frame on MDC/MDIO. For reads it captures 16 bits from the PHY, then clears the start bit, which doubles as the busy flag.

MDC is derived from the system clock by the parameter `CLK_DIV` and sits low between transactions. MDIO is driven on the falling MDC edge and sampled on the rising edge. During a read the MDIO driver is released from the turnaround field onward. An enable bit in the control register gates start requests.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control register reads 0, the read-data register reads 0, MDC is low and the MDIO output enable is 0.
- R2: Register select 0 is the command word: bits 4:0 register number, bits 9:5 PHY address, bit 10 direction (1 read, 0 write); select 1 is write data in bits 15:0. Both read back as written, with upper bits reading 0.
- R3: In the control register (select 3), bit 3 is the enable and reads back as written. Bit 0 is status: it reads 1 from the cycle after an accepted start until the frame ends.
- R4: A control write with bit 0 set starts a frame only if bit 3 is also set in that write; otherwise status stays 0 and MDC and MDIO stay idle.
- R5: While a frame runs, MDC has a period of `CLK_DIV` system clocks. MDC is low whenever no frame runs.
- R6: Each frame, sampled at rising MDC edges, is 32 ones, 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register number, then turnaround 10 and 16 write data bits MSB first for writes.
- R7: During a read the output enable drops for the last 18 bits (turnaround and data). MDIO input is sampled on the rising MDC edges of the 16 data bits, MSB first, and appears in the read-data register (select 2, bits 15:0) when the frame ends. The read-data register changes at no other time.
- R8: Status stays 1 for exactly 64 × `CLK_DIV` system clocks per frame.
- R9: Control or command writes during a frame neither restart nor alter the frame in flight; the new command value is still stored.
- R10: Writes to the read-data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 command, 1 write data, 2 read data, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or shift register shows as a corrupted field in the frame at the very next rising MDC edge. It also shows as a status bit that clears early or late against the exact 64 × `CLK_DIV` window. A wrong sampling phase or order shows as a shifted or reversed read value in the first read. Several distinct response patterns, including all-ones and all-zeros, catch that case. A wrong enable or busy gate shows as MDC activity or a restarted frame within a few clocks of the offending control write.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [10:0]   cmd_q;
  logic [15:0]   wd_q;
  logic [15:0]   rd_q;
  logic [15:0]   cap_q;
  logic          en_q;
  logic          busy;
  logic          op_rd;
  logic          mdc_q;
  logic [CW-1:0] div_cnt;
  logic [5:0]    bit_cnt;
  logic [63:0]   frame;

  wire tick  = busy && (div_cnt == CW'(HALF - 1));
  wire start = reg_wr && (reg_sel == 2'd3) && reg_wdata[0] && reg_wdata[3] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      cap_q   <= '0;
      en_q    <= 1'b0;
      busy    <= 1'b0;
      op_rd   <= 1'b0;
      mdc_q   <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      frame   <= '1;
    end else begin
      if (reg_wr && reg_sel == 2'd0) cmd_q <= reg_wdata[10:0];
      if (reg_wr && reg_sel == 2'd1) wd_q  <= reg_wdata[15:0];
      if (reg_wr && reg_sel == 2'd3) en_q  <= reg_wdata[3];
      if (start) begin
        busy    <= 1'b1;
        op_rd   <= cmd_q[10];
        mdc_q   <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
        frame   <= {32'hFFFF_FFFF, 2'b01, cmd_q[10] ? 2'b10 : 2'b01, cmd_q[9:5], cmd_q[4:0],
                    cmd_q[10] ? 2'b11 : 2'b10, cmd_q[10] ? 16'hFFFF : wd_q};
      end else if (tick) begin
        div_cnt <= '0;
        mdc_q   <= ~mdc_q;
        if (!mdc_q) begin
          if (op_rd && bit_cnt >= 6'd48) cap_q <= {cap_q[14:0], mdio_i};
        end else if (bit_cnt == 6'd63) begin
          busy <= 1'b0;
          if (op_rd) rd_q <= cap_q;
        end else begin
          bit_cnt <= bit_cnt + 6'd1;
          frame   <= {frame[62:0], 1'b1};
        end
      end else if (busy) begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = busy ? frame[63] : 1'b1;
  assign mdio_oe = busy && !(op_rd && bit_cnt >= 6'd46);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {21'b0, cmd_q};
      2'd1:    reg_rdata = {16'b0, wd_q};
      2'd2:    reg_rdata = {16'b0, rd_q};
      default: reg_rdata = {28'b0, en_q, 2'b00, busy};
    endcase
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en_q); // R4
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5
  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_cnt < 6'd32) |-> (mdio_o && mdio_oe)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(rd_q)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bit_cnt >= $past(bit_cnt))); // R9
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int PERIOD = 10;
  localparam int DIV    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  mdio_mgmt_master #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int g = 0; g < 4000; g++) begin
      rd(2'd3, d);
      if (!d[0]) return;
    end
    chk(1'b0, "R8 status never cleared", 64'd1, 64'd0);
  endtask

  function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] rn,
                                            input bit rdop, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rdop ? 2'b10 : 2'b01, phy, rn,
            rdop ? 2'b00 : 2'b10, rdop ? 16'h0000 : wd};
  endfunction

  task automatic txn(input logic [4:0] phy, input logic [4:0] rn, input bit rdop,
                     input logic [15:0] wd, input logic [15:0] rv, input bit disturb);
    logic [63:0] got, oeg, ef, om;
    logic [31:0] d;
    logic [10:0] cmd;
    time t0, t1;
    cmd = {rdop, phy, rn};
    wr(2'd0, {21'b0, cmd});
    wr(2'd1, {16'b0, wd});
    wr(2'd3, 32'h9);
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) t0 = $time;
      if (k == 1) t1 = $time;
      #1;
      got[63-k] = mdio_o;
      oeg[63-k] = mdio_oe;
      if (k >= 47 && k <= 62) mdio_i = rv[62-k];
      else mdio_i = 1'b1;
      if (disturb && k == 10) begin
        wr(2'd0, {21'b0, cmd ^ 11'h7FF});
        wr(2'd3, 32'h9);
      end
    end
    wait_idle();
    ef = exp_frame(phy, rn, rdop, wd);
    om = rdop ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    chk(((got ^ ef) & om) == 64'd0, disturb ? "R9 frame altered" : "R6 frame", got & om, ef & om);
    chk(oeg == om, "R7 output enable", oeg, om);
    chk((t1 - t0) == DIV * PERIOD, "R5 mdc period", 64'(t1 - t0), 64'(DIV * PERIOD));
    if (rdop) begin
      rd(2'd2, d);
      chk(d == {16'b0, rv}, "R7 read data", {32'b0, d}, {48'b0, rv});
    end
    if (disturb) begin
      rd(2'd0, d);
      chk(d == {21'b0, cmd ^ 11'h7FF}, "R9 command stored", {32'b0, d}, {53'b0, cmd ^ 11'h7FF});
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    bit mdc_seen;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd3, d); chk(d == 32'd0, "R1 control", {32'b0, d}, 64'd0);
    rd(2'd2, d); chk(d == 32'd0, "R1 read data", {32'b0, d}, 64'd0);
    chk(!mdc && !mdio_oe, "R1 pins", {62'b0, mdc, mdio_oe}, 64'd0);

    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d);
    chk(d == 32'h7FF, "R2 command width", {32'b0, d}, 64'h7FF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d);
    chk(d == 32'hFFFF, "R2 write data width", {32'b0, d}, 64'hFFFF);
    wr(2'd0, 32'h0000_0123); rd(2'd0, d);
    chk(d == 32'h123, "R2 command readback", {32'b0, d}, 64'h123);

    wr(2'd3, 32'h8); rd(2'd3, d);
    chk(d == 32'h8, "R3 enable readback", {32'b0, d}, 64'h8);
    wr(2'd3, 32'h1);
    mdc_seen = 1'b0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) mdc_seen = 1'b1;
    end
    chk(!mdc_seen, "R4 idle pins", {63'b0, mdc_seen}, 64'd0);
    rd(2'd3, d); chk(d == 32'd0, "R4 start ignored", {32'b0, d}, 64'd0);

    wr(2'd0, {21'b0, 1'b0, 5'd3, 5'd9});
    wr(2'd3, 32'h9);
    cnt = 0;
    rd(2'd3, d);
    while (d[0] && cnt < 5000) begin
      cnt++;
      @(negedge clk);
      #1 d = reg_rdata;
    end
    chk(cnt == 64 * DIV - 1, "R8 busy length", 64'(cnt + 1), 64'(64 * DIV));
    chk(d == 32'h8, "R3 status clears", {32'b0, d}, 64'h8);

    txn(5'd31, 5'd31, 1'b1, 16'h0, 16'hFFFF, 1'b0);
    txn(5'd0, 5'd0, 1'b1, 16'h0, 16'h0000, 1'b0);
    txn(5'd1, 5'd1, 1'b1, 16'h0, 16'hA5C3, 1'b0);
    txn(5'd0, 5'd0, 1'b0, 16'h0001, 16'h0, 1'b0);
    txn(5'd17, 5'd2, 1'b0, 16'h8000, 16'h0, 1'b1);
    txn(5'd6, 5'd14, 1'b1, 16'h0, 16'h1E69, 1'b1);

    wr(2'd2, 32'h0000_1234); rd(2'd2, d);
    chk(d == 32'h1E69, "R10 read data not writable", {32'b0, d}, 64'h1E69);

    for (int i = 0; i < 24; i++) begin
      txn(5'($urandom), 5'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule